// File: doc/BRIEF.md
# Wear-Aware Line Flush Cache Controller

This block holds the tag, valid, dirty, data and recency state of a small set-associative cache whose storage cells wear out with writes. It spreads writes within a set by occasionally sending a write hit past its line: one counter shared by the whole cache tallies write hits. When the tally reaches a programmable threshold, the line hit by that write is invalidated. The write data leave through the write-back port and do not land in the line. Lines that are written often are therefore the likeliest to be pushed out. They come back later into whichever way is least recently used.

A requester presents lookups (set, tag, read or write, data) on a valid/ready channel and receives one response per accepted lookup, exactly one cycle later. A miss changes no state. The requester fetches the line elsewhere and installs it through the refill channel (valid/ready). The refill replaces the way of age 0 and writes back that way first if it is dirty. Write-backs leave on a valid/ready channel. Back-pressure rules: while a write-back is pending (`wb_valid` high), both `req_ready` and `fill_ready` are low. While `fill_valid` is high, `req_ready` is low, so a refill always goes before a lookup offered in the same cycle. The payload on `wb_*` holds steady until `wb_ready` is seen.

Top module: `wlf_cache_ctrl`

## Requirements
- R1: After reset every line is invalid and clean, way w of each set has age w, the hit counter is 0, `req_ready` and `fill_ready` are high, and `wb_valid` and `resp_valid` are low.
- R2: An accepted lookup gives `resp_valid` in the next cycle. A read hit returns the stored line data. A miss gives `resp_hit`=0 and `resp_rdata`=0 and changes no line, age or counter. `resp_rdata` is 0 for every write.
- R3: The one shared counter advances only on write hits. Read hits, read misses and write misses leave it unchanged.
- R4: A write hit that brings the counter to the threshold (a threshold of 0 acts as 1) flushes. The line becomes invalid and its data are not updated. `resp_flush`=1. A write-back carries the lookup's set, tag and write data. The counter returns to 0.
- R5: With threshold 1 every write hit flushes. With threshold 2 every second write hit flushes.
- R6: A write hit that does not flush stores its data in the line and marks it dirty. A later read hit returns the new data.
- R7: Ages form a full order per set. A read hit, a non-flushing write hit or a refill makes the touched way age WAYS-1, and each way older than its previous age loses one.
- R8: A flush leaves the line's age unchanged. A refill never picks a flushed way until that way has age 0.
- R9: A refill installs a clean valid line in the way of age 0. If that way held valid dirty data, a write-back with its set, old tag and data is issued first. A clean or invalid victim causes none.
- R10: `wb_valid` and the `wb_*` payload stay steady until `wb_ready` is high. Meanwhile neither lookups nor refills are accepted.
- R11: When a refill and a lookup are both offered, the refill is accepted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup offered |
| req_ready | output | 1 | Lookup can be accepted |
| req_set | input | SET_W | Lookup set index |
| req_tag | input | TAG_W | Lookup tag |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response for the lookup accepted last cycle |
| resp_hit | output | 1 | Lookup hit a valid line |
| resp_flush | output | 1 | Write hit was flushed instead of stored |
| resp_rdata | output | DATA_W | Read hit data, else 0 |
| fill_valid | input | 1 | Refill offered |
| fill_ready | output | 1 | Refill can be accepted |
| fill_set | input | SET_W | Refill set index |
| fill_tag | input | TAG_W | Refill tag |
| fill_data | input | DATA_W | Refill line data |
| wb_valid | output | 1 | Write-back pending |
| wb_ready | input | 1 | Write-back taken |
| wb_set | output | SET_W | Write-back set |
| wb_tag | output | TAG_W | Write-back tag |
| wb_data | output | DATA_W | Write-back data |
| flush_thresh | input | CNT_W | Write hits per flush (0 acts as 1) |

## Verification
A counter that advances on the wrong events moves the next flush earlier or later. That shows up as a wrong `resp_flush` and a missing or extra write-back on the first write hit that should or should not flush. A corrupted age order first shows at the next refill of that set. There the victim shows as a write-back with the wrong tag, or as no write-back where one is due, and as a later read hitting or missing the wrong tag. A flush that wrongly stores data, or wrongly clears age, is caught by reads and refills that follow it in the same set.

// File: rtl/wlf_pkg.sv
`timescale 1ns/1ps
package wlf_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_LOOKUP, OP_FILL} op_e;
endpackage

// File: rtl/wlf_way_match.sv
`timescale 1ns/1ps
module wlf_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic [WAYS-1:0]       vld,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      key,
  output logic                  hit,
  output logic [IDX_W-1:0]      way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = vld[w] && (tags[w*TAG_W +: TAG_W] == key);
  end

  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (eq[w] && !hit) begin
        hit = 1'b1;
        way = IDX_W'(w);
      end
    end
  end
endmodule

// File: rtl/wlf_age_next.sv
`timescale 1ns/1ps
module wlf_age_next #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2
) (
  input  logic [WAYS*AGE_W-1:0] ages_in,
  input  logic [AGE_W-1:0]      touch,
  output logic [WAYS*AGE_W-1:0] ages_out,
  output logic [AGE_W-1:0]      lru
);
  localparam logic [AGE_W-1:0] TOP = AGE_W'(WAYS - 1);
  logic [AGE_W-1:0] ref_age;

  assign ref_age = ages_in[touch*AGE_W +: AGE_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    logic [AGE_W-1:0] a;
    assign a = ages_in[w*AGE_W +: AGE_W];
    assign ages_out[w*AGE_W +: AGE_W] =
      (touch == AGE_W'(w)) ? TOP :
      (a > ref_age)        ? a - 1'b1 : a;
  end

  always_comb begin
    lru = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ages_in[w*AGE_W +: AGE_W] == '0) lru = AGE_W'(w);
    end
  end
endmodule

// File: rtl/wlf_hit_ctr.sv
`timescale 1ns/1ps
module wlf_hit_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] thresh,
  output logic             flush_now
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   next_cnt;
  logic [CNT_W:0]   limit;

  assign next_cnt  = {1'b0, cnt_q} + 1'b1;
  assign limit     = (thresh == '0) ? (CNT_W+1)'(1) : {1'b0, thresh};
  assign flush_now = wr_hit && (next_cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (flush_now) cnt_q <= '0;
    else if (wr_hit)    cnt_q <= next_cnt[CNT_W-1:0];
  end
endmodule

// File: rtl/wlf_cache_ctrl.sv
`timescale 1ns/1ps
module wlf_cache_ctrl import wlf_pkg::*; #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SET_W-1:0]  req_set,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_flush,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [SET_W-1:0]  wb_set,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data,
  input  logic [CNT_W-1:0]  flush_thresh
);
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];
  logic [WAY_W-1:0]  age_q  [SETS][WAYS];
  logic              vld_q  [SETS][WAYS];
  logic              dirty_q[SETS][WAYS];

  logic fill_go, req_go, hit, wr_hit, flush_now, touch_en;
  logic [SET_W-1:0]      sel_set;
  logic [WAYS-1:0]       cur_vld;
  logic [WAYS*TAG_W-1:0] cur_tags;
  logic [WAYS*WAY_W-1:0] cur_ages, nxt_ages;
  logic [WAY_W-1:0]      hit_way, lru_way, touch_way;
  op_e                   op;

  assign fill_ready = !wb_valid;
  assign req_ready  = !wb_valid && !fill_valid;
  assign fill_go    = fill_valid && fill_ready;
  assign req_go     = req_valid && req_ready;
  assign sel_set    = fill_go ? fill_set : req_set;
  assign op         = fill_go ? OP_FILL : (req_go ? OP_LOOKUP : OP_IDLE);

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      cur_vld[w]                   = vld_q[sel_set][w];
      cur_tags[w*TAG_W +: TAG_W]   = tag_q[sel_set][w];
      cur_ages[w*WAY_W +: WAY_W]   = age_q[sel_set][w];
    end
  end

  wlf_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(WAY_W)) u_match (
    .vld(cur_vld), .tags(cur_tags), .key(req_tag), .hit(hit), .way(hit_way)
  );

  assign wr_hit    = req_go && hit && req_write;
  assign touch_way = fill_go ? lru_way : hit_way;

  wlf_hit_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .thresh(flush_thresh),
    .flush_now(flush_now)
  );

  wlf_age_next #(.WAYS(WAYS), .AGE_W(WAY_W)) u_age (
    .ages_in(cur_ages), .touch(touch_way), .ages_out(nxt_ages), .lru(lru_way)
  );

  assign touch_en = (op == OP_FILL) || ((op == OP_LOOKUP) && hit && !flush_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]   <= '0;
          data_q[s][w]  <= '0;
          age_q[s][w]   <= WAY_W'(w);
          vld_q[s][w]   <= 1'b0;
          dirty_q[s][w] <= 1'b0;
        end
      end
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_flush <= 1'b0;
      resp_rdata <= '0;
      wb_valid   <= 1'b0;
      wb_set     <= '0;
      wb_tag     <= '0;
      wb_data    <= '0;
    end else begin
      resp_valid <= (op == OP_LOOKUP);
      if (wb_valid && wb_ready) wb_valid <= 1'b0;
      if (touch_en) begin
        for (int w = 0; w < WAYS; w++) age_q[sel_set][w] <= nxt_ages[w*WAY_W +: WAY_W];
      end
      case (op)
        OP_LOOKUP: begin
          resp_hit   <= hit;
          resp_flush <= flush_now;
          resp_rdata <= (hit && !req_write) ? data_q[sel_set][hit_way] : '0;
          if (wr_hit) begin
            if (flush_now) begin
              vld_q[sel_set][hit_way]   <= 1'b0;
              dirty_q[sel_set][hit_way] <= 1'b0;
              wb_valid <= 1'b1;
              wb_set   <= req_set;
              wb_tag   <= req_tag;
              wb_data  <= req_wdata;
            end else begin
              data_q[sel_set][hit_way]  <= req_wdata;
              dirty_q[sel_set][hit_way] <= 1'b1;
            end
          end
        end
        OP_FILL: begin
          if (vld_q[sel_set][lru_way] && dirty_q[sel_set][lru_way]) begin
            wb_valid <= 1'b1;
            wb_set   <= fill_set;
            wb_tag   <= tag_q[sel_set][lru_way];
            wb_data  <= data_q[sel_set][lru_way];
          end
          tag_q[sel_set][lru_way]   <= fill_tag;
          data_q[sel_set][lru_way]  <= fill_data;
          vld_q[sel_set][lru_way]   <= 1'b1;
          dirty_q[sel_set][lru_way] <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wlf_cache_chk.sv
`timescale 1ns/1ps
module wlf_cache_chk #(
  parameter int SET_W  = 2,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              resp_flush,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [SET_W-1:0]  wb_set,
  input logic [TAG_W-1:0]  wb_tag,
  input logic [DATA_W-1:0] wb_data
);
  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_tag) && $stable(wb_set));
  // R2
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid);
  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid);
  // R4
  flush_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_flush |-> resp_hit && wb_valid);
  // R2
  miss_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_hit |-> resp_rdata == '0);
endmodule

bind wlf_cache_ctrl wlf_cache_chk #(.SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_flush(resp_flush),
  .resp_rdata(resp_rdata), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_set(wb_set), .wb_tag(wb_tag), .wb_data(wb_data)
);

// File: tb/sim_wlf_cache_ctrl.sv
`timescale 1ns/1ps
module sim_wlf_cache_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, fill_valid = 1'b0, wb_ready = 1'b1;
  logic [1:0]  req_set = '0, fill_set = '0;
  logic [7:0]  req_tag = '0, fill_tag = '0, flush_thresh = 8'd3;
  logic [15:0] req_wdata = '0, fill_data = '0;
  logic req_ready, fill_ready, resp_valid, resp_hit, resp_flush, wb_valid;
  logic [15:0] resp_rdata, wb_data;
  logic [1:0]  wb_set;
  logic [7:0]  wb_tag;

  wlf_cache_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_tag(req_tag), .req_write(req_write), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_flush(resp_flush),
    .resp_rdata(resp_rdata), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_set(fill_set), .fill_tag(fill_tag), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_set(wb_set), .wb_tag(wb_tag),
    .wb_data(wb_data), .flush_thresh(flush_thresh)
  );

  int n_cmp = 0, n_bad = 0;
  typedef struct { logic hit; logic fl; logic [15:0] d; string rq; } rexp_t;
  typedef struct { logic [1:0] s; logic [7:0] t; logic [15:0] d; string rq; } wexp_t;
  rexp_t rsp_q[$];
  wexp_t wb_q[$];

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (resp_valid) begin
        rexp_t e;
        if (rsp_q.size() == 0) check(1'b0, "R2", "unexpected response", 1, 0);
        else begin
          e = rsp_q.pop_front();
          check(resp_hit == e.hit, e.rq, "resp_hit", 32'(resp_hit), 32'(e.hit));
          check(resp_flush == e.fl, e.rq, "resp_flush", 32'(resp_flush), 32'(e.fl));
          check(resp_rdata == e.d, e.rq, "resp_rdata", 32'(resp_rdata), 32'(e.d));
        end
      end
      if (wb_valid && wb_ready) begin
        wexp_t w;
        if (wb_q.size() == 0)
          check(1'b0, "R9", "unexpected write-back", {6'd0, wb_set, wb_tag, wb_data}, 0);
        else begin
          w = wb_q.pop_front();
          check({wb_set, wb_tag, wb_data} == {w.s, w.t, w.d}, w.rq, "write-back",
                {6'd0, wb_set, wb_tag, wb_data}, {6'd0, w.s, w.t, w.d});
        end
      end
    end
  end

  task automatic lookup(input logic [1:0] s, input logic [7:0] t, input logic w,
                        input logic [15:0] d, input logic eh, input logic ef,
                        input logic [15:0] ed, input string rq);
    rsp_q.push_back('{eh, ef, ed, rq});
    @(posedge clk); #1;
    req_valid = 1'b1; req_set = s; req_tag = t; req_write = w; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic refill(input logic [1:0] s, input logic [7:0] t, input logic [15:0] d);
    @(posedge clk); #1;
    fill_valid = 1'b1; fill_set = s; fill_tag = t; fill_data = d;
    @(negedge clk);
    while (!fill_ready) @(negedge clk);
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic expect_wb(input logic [1:0] s, input logic [7:0] t, input logic [15:0] d,
                           input string rq);
    wb_q.push_back('{s, t, d, rq});
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 1);
    check(fill_ready == 1'b1, "R1", "fill_ready", 32'(fill_ready), 1);
    check(wb_valid == 1'b0, "R1", "wb_valid", 32'(wb_valid), 0);
    check(resp_valid == 1'b0, "R1", "resp_valid", 32'(resp_valid), 0);
    lookup(2'd1, 8'h11, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, "R1 empty miss");

    // R9: fill set 1 with A,B,C,D into ways 0..3 (clean/invalid victims, no write-back)
    refill(2'd1, 8'h11, 16'h1111);
    refill(2'd1, 8'h22, 16'h2222);
    refill(2'd1, 8'h33, 16'h3333);
    refill(2'd1, 8'h44, 16'h4444);
    lookup(2'd1, 8'h11, 1'b0, 16'h0, 1'b1, 1'b0, 16'h1111, "R2 read hit");
    // threshold 3: first write hit stores (R6)
    lookup(2'd1, 8'h22, 1'b1, 16'hBEEF, 1'b1, 1'b0, 16'h0, "R6 write hit store");
    // R3: misses and reads do not count
    lookup(2'd1, 8'h99, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, "R3 read miss");
    lookup(2'd1, 8'h99, 1'b1, 16'h5A5A, 1'b0, 1'b0, 16'h0, "R3 write miss");
    lookup(2'd1, 8'h33, 1'b0, 16'h0, 1'b1, 1'b0, 16'h3333, "R3 read hit");
    lookup(2'd1, 8'h44, 1'b1, 16'hD0D0, 1'b1, 1'b0, 16'h0, "R3 second write hit");
    lookup(2'd1, 8'h22, 1'b0, 16'h0, 1'b1, 1'b0, 16'hBEEF, "R6 read new data");
    // third write hit reaches threshold 3: flush (R4)
    expect_wb(2'd1, 8'h33, 16'hC0C0, "R4 flush write-back");
    lookup(2'd1, 8'h33, 1'b1, 16'hC0C0, 1'b1, 1'b1, 16'h0, "R4 flush");
    lookup(2'd1, 8'h33, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, "R4 flushed line misses");
    // R8/R7: refill picks the true LRU (A, clean), not the flushed line
    refill(2'd1, 8'h55, 16'h5555);
    lookup(2'd1, 8'h11, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, "R8 LRU way replaced");
    // flushed way is now LRU: used next, no write-back (R8)
    refill(2'd1, 8'h66, 16'h6666);
    // victim D dirty, hold write-back port (R10)
    expect_wb(2'd1, 8'h44, 16'hD0D0, "R9 dirty victim D");
    wb_ready = 1'b0;
    refill(2'd1, 8'h77, 16'h7777);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(wb_valid == 1'b1, "R10", "wb_valid held", 32'(wb_valid), 1);
      check(req_ready == 1'b0, "R10", "req_ready stalled", 32'(req_ready), 0);
      check(fill_ready == 1'b0, "R10", "fill_ready stalled", 32'(fill_ready), 0);
    end
    @(posedge clk); #1 wb_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check(wb_valid == 1'b0, "R10", "wb_valid drops", 32'(wb_valid), 0);
    expect_wb(2'd1, 8'h22, 16'hBEEF, "R9 dirty victim B");
    refill(2'd1, 8'h88, 16'h8888);
    lookup(2'd1, 8'h55, 1'b0, 16'h0, 1'b1, 1'b0, 16'h5555, "R7 refilled E");
    lookup(2'd1, 8'h44, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, "R9 evicted D");
    lookup(2'd1, 8'h66, 1'b0, 16'h0, 1'b1, 1'b0, 16'h6666, "R8 F in flushed way");

    // R5: threshold 2, every other write hit flushes (set 2)
    flush_thresh = 8'd2;
    refill(2'd2, 8'h21, 16'h0000);
    lookup(2'd2, 8'h21, 1'b1, 16'h0A01, 1'b1, 1'b0, 16'h0, "R5 FT2 first");
    expect_wb(2'd2, 8'h21, 16'h0A02, "R5 FT2 wb");
    lookup(2'd2, 8'h21, 1'b1, 16'h0A02, 1'b1, 1'b1, 16'h0, "R5 FT2 second");
    lookup(2'd2, 8'h21, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, "R5 FT2 miss after");
    // threshold 1: every write hit flushes; reads do not
    flush_thresh = 8'd1;
    refill(2'd2, 8'h21, 16'h2121);
    lookup(2'd2, 8'h21, 1'b0, 16'h0, 1'b1, 1'b0, 16'h2121, "R3 FT1 read no flush");
    expect_wb(2'd2, 8'h21, 16'h0A03, "R5 FT1 wb");
    lookup(2'd2, 8'h21, 1'b1, 16'h0A03, 1'b1, 1'b1, 16'h0, "R5 FT1 write");
    // threshold 0 behaves as 1
    flush_thresh = 8'd0;
    refill(2'd2, 8'h21, 16'h0000);
    expect_wb(2'd2, 8'h21, 16'h0A04, "R4 FT0 wb");
    lookup(2'd2, 8'h21, 1'b1, 16'h0A04, 1'b1, 1'b1, 16'h0, "R4 FT0 write");

    // R11: refill and lookup offered together, refill goes first
    rsp_q.push_back('{1'b1, 1'b0, 16'h3131, "R11 lookup after refill"});
    @(posedge clk); #1;
    fill_valid = 1'b1; fill_set = 2'd3; fill_tag = 8'h31; fill_data = 16'h3131;
    req_valid = 1'b1; req_set = 2'd3; req_tag = 8'h31; req_write = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b0, "R11", "req_ready with fill", 32'(req_ready), 0);
    check(fill_ready == 1'b1, "R11", "fill_ready", 32'(fill_ready), 1);
    @(posedge clk); #1 fill_valid = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;

    repeat (5) @(posedge clk);
    @(negedge clk);
    check(rsp_q.size() == 0, "R2", "pending responses", rsp_q.size(), 0);
    check(wb_q.size() == 0, "R9", "pending write-backs", wb_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule